// File: doc/BRIEF.md
# Seat Belt Reminder Controller

This block watches two occupant sensors and sounds a buzzer when someone sits down but does not fasten the belt within a fixed grace period. The seat and belt signals arrive asynchronously. Each one passes through a two-stage synchronizer before it reaches a four-state controller. The controller has an empty state, a seated-and-waiting state, a belted state and an alarm state.

On each entry into the waiting state the controller loads an internal down-counter with the grace interval in clock cycles. It also emits a one-cycle start pulse. When the counter reaches zero and the belt is still open, the controller enters the alarm state, and the buzzer stays on until the belt closes or the occupant leaves. Leaving the seat always returns the controller to the empty state. The current state is brought out so that the surrounding logic can see the occupancy condition.

Top module: `seatbelt_reminder`

## Requirements
- R1: A synchronous active-high `rst` drives `state_o` to 0 (empty), with `buzzer` and `timer_start` at 0, on the clock edge that samples it.
- R2: While the synchronized seat input is low, the controller stays in empty (code 0) whatever the belt input does.
- R3: A seat rising in empty moves the controller to seated (code 1). `timer_start` is high for exactly the first cycle spent in seated.
- R4: A change on `seat_in` or `belt_in` applied before a clock edge reaches `state_o` on the third edge: two synchronizer stages plus the state register.
- R5: With the belt open, the controller stays in seated for DELAY_CYCLES+1 cycles and then enters alarm (code 3). `buzzer` is high exactly while the state is alarm.
- R6: A belt that closes while in seated, before the interval runs out, moves the controller to belted (code 2), and `buzzer` stays low.
- R7: If the belt closure and the timer expiry are seen in seated on the same cycle, the controller goes to belted and not to alarm.
- R8: The seat going low moves seated, belted or alarm to empty on the next state update.
- R9: A belt that closes in alarm moves the controller to belted and turns `buzzer` off.
- R10: A belt that opens in belted, with the seat still occupied, moves the controller to seated. This raises `timer_start` again and restarts the full DELAY_CYCLES+1 interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seat_in | input | 1 | Seat occupancy sensor, asynchronous |
| belt_in | input | 1 | Belt fastened sensor, asynchronous |
| buzzer | output | 1 | Alarm output, high in the alarm state |
| timer_start | output | 1 | One-cycle pulse on each start of the grace interval |
| state_o | output | 2 | Controller state: 0 empty, 1 seated, 2 belted, 3 alarm |

## Verification
The bench builds the block with DELAY_CYCLES set to 6. This makes the full grace interval a handful of cycles, so the exact cycle of alarm entry can be checked directly. A six-cycle interval also lets the bench place a belt closure on the very cycle of expiry, and then one cycle later. Those two placements separate the belt-priority rule from the normal alarm-then-belted path. The short interval also lets the bench check a full restart of the timer after unbelting against the same cycle count.

// File: rtl/seatbelt_pkg.sv
package seatbelt_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_WAIT   = 2'd1,
        ST_BELTED = 2'd2,
        ST_ALARM  = 2'd3
    } occ_state_t;

    typedef struct packed {
        logic seat;
        logic belt;
    } sensor_t;

    localparam int unsigned SYNC_STAGES = 2;

    // Next-state rule; leaving the seat dominates, then the belt, then expiry.
    function automatic occ_state_t occ_next(occ_state_t cur, sensor_t s, logic expired);
        occ_state_t nxt;
        nxt = cur;
        if (!s.seat) begin
            nxt = ST_EMPTY;
        end else begin
            unique case (cur)
                ST_EMPTY:  nxt = ST_WAIT;
                ST_WAIT:   begin
                    if (s.belt)       nxt = ST_BELTED;
                    else if (expired) nxt = ST_ALARM;
                end
                ST_BELTED: if (!s.belt) nxt = ST_WAIT;
                ST_ALARM:  if (s.belt)  nxt = ST_BELTED;
                default:   nxt = ST_EMPTY;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/sb_sync.sv
module sb_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sb_grace_timer.sv
module sb_grace_timer #(
    parameter int unsigned DELAY_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic clear,
    output logic expired
);
    localparam int unsigned CNT_W = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DELAY_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
            run_q <= 1'b1;
        end else if (run_q && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == '0);
endmodule

// File: rtl/sb_fsm.sv
module sb_fsm
    import seatbelt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sensor_t    sens,
    input  logic       expired,
    output occ_state_t state,
    output logic       tmr_load,
    output logic       tmr_clear,
    output logic       start_pulse
);
    occ_state_t state_q, state_d;
    logic       start_q;

    always_comb begin
        state_d   = occ_next(state_q, sens, expired);
        tmr_load  = (state_d == ST_WAIT) && (state_q != ST_WAIT);
        tmr_clear = (state_d != ST_WAIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= tmr_load;
        end
    end

    assign state       = state_q;
    assign start_pulse = start_q;
endmodule

// File: rtl/seatbelt_reminder.sv
module seatbelt_reminder
    import seatbelt_pkg::*;
#(
    parameter int unsigned DELAY_CYCLES = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       seat_in,
    input  logic       belt_in,
    output logic       buzzer,
    output logic       timer_start,
    output logic [1:0] state_o
);
    localparam int unsigned SENS_W = $bits(sensor_t);

    sensor_t          raw_sens;
    sensor_t          sens;
    logic [SENS_W-1:0] sync_q;
    logic             seat_s, belt_s;
    logic             tmr_expired, tmr_load, tmr_clear;
    occ_state_t       state;

    assign raw_sens.seat = seat_in;
    assign raw_sens.belt = belt_in;

    sb_sync #(.WIDTH(SENS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_sens),
        .q   (sync_q)
    );

    assign sens   = sensor_t'(sync_q);
    assign seat_s = sens.seat;
    assign belt_s = sens.belt;

    sb_grace_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .clear   (tmr_clear),
        .expired (tmr_expired)
    );

    sb_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sens        (sens),
        .expired     (tmr_expired),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_clear   (tmr_clear),
        .start_pulse (timer_start)
    );

    assign state_o = state;
    assign buzzer  = (state == ST_ALARM);
endmodule

// File: rtl/seatbelt_reminder_chk.sv
module seatbelt_reminder_chk #(
    parameter int unsigned DELAY_CYCLES = 100000
) (
    input logic       clk,
    input logic       rst,
    input logic       seat_s,
    input logic       belt_s,
    input logic       expired,
    input logic [1:0] state_o,
    input logic       buzzer,
    input logic       timer_start
);
    localparam int unsigned CW = $clog2(DELAY_CYCLES + 3) + 1;

    logic [CW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || state_o != 2'd1) wait_cnt <= '0;
        else if (wait_cnt != '1)    wait_cnt <= wait_cnt + 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_o == 2'd0 && !buzzer && !timer_start));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && !seat_s) |=> state_o == 2'd0);

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        timer_start |=> !timer_start);

    // R5
    alarm_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(buzzer) |-> ($past(expired) && $past(state_o) == 2'd1));

    // R5
    alarm_delay_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(buzzer) |-> wait_cnt == CW'(DELAY_CYCLES + 1));

    // R7
    belt_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1 && seat_s && belt_s) |=> state_o == 2'd2);

    // R8
    leave_seat_chk: assert property (@(posedge clk) disable iff (rst)
        (!seat_s && state_o != 2'd0) |=> state_o == 2'd0);

    // R10
    unbelt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2 && seat_s && !belt_s) |=> (state_o == 2'd1 && timer_start));
endmodule

bind seatbelt_reminder seatbelt_reminder_chk #(.DELAY_CYCLES(DELAY_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .seat_s      (seat_s),
    .belt_s      (belt_s),
    .expired     (tmr_expired),
    .state_o     (state_o),
    .buzzer      (buzzer),
    .timer_start (timer_start)
);

// File: tb/seatbelt_reminder_test.sv
`timescale 1ns/1ps
module seatbelt_reminder_test;
    localparam int unsigned D = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       seat_in = 1'b0;
    logic       belt_in = 1'b0;
    logic       buzzer, timer_start;
    logic [1:0] state_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    seatbelt_reminder #(.DELAY_CYCLES(D)) uut (
        .clk(clk), .rst(rst), .seat_in(seat_in), .belt_in(belt_in),
        .buzzer(buzzer), .timer_start(timer_start), .state_o(state_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // {seat, belt, cycles[7:0], state[1:0], buzzer}
    localparam logic [12:0] SEQ [12] = '{
        {1'b0, 1'b0, 8'd5,  2'd0, 1'b0},  // R2 empty
        {1'b0, 1'b1, 8'd5,  2'd0, 1'b0},  // R2 belt alone ignored
        {1'b1, 1'b1, 8'd5,  2'd2, 1'b0},  // R6 sit already belted
        {1'b0, 1'b1, 8'd5,  2'd0, 1'b0},  // R8 leave from belted
        {1'b0, 1'b0, 8'd4,  2'd0, 1'b0},  // R2
        {1'b1, 1'b0, 8'd5,  2'd1, 1'b0},  // R3 seated waiting
        {1'b1, 1'b0, 8'd10, 2'd3, 1'b1},  // R5 alarm
        {1'b0, 1'b0, 8'd5,  2'd0, 1'b0},  // R8 leave from alarm
        {1'b1, 1'b0, 8'd15, 2'd3, 1'b1},  // R5 alarm again
        {1'b1, 1'b1, 8'd5,  2'd2, 1'b0},  // R9 belt clears alarm
        {1'b1, 1'b0, 8'd5,  2'd1, 1'b0},  // R10 unbelt back to seated
        {1'b0, 1'b0, 8'd5,  2'd0, 1'b0}   // R8 leave from seated
    };

    initial begin
        @(negedge clk);
        step(3);
        // R1 reset state
        chk("R1 reset state", state_o, 0);
        chk("R1 reset buzzer", buzzer, 0);
        chk("R1 reset timer_start", timer_start, 0);
        rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            seat_in = SEQ[i][12];
            belt_in = SEQ[i][11];
            step(int'(SEQ[i][10:3]));
            chk($sformatf("R2/R3/R5/R6/R8/R9/R10 table row %0d state", i), state_o, int'(SEQ[i][2:1]));
            chk($sformatf("R5 table row %0d buzzer", i), buzzer, int'(SEQ[i][0]));
        end

        // R4 / R3 / R5 exact timing from empty
        seat_in = 1'b1;
        step(2);
        chk("R4 no state change after two edges", state_o, 0);
        step(1);
        chk("R4 seated on third edge", state_o, 1);
        chk("R3 timer_start on entry", timer_start, 1);
        step(1);
        chk("R3 timer_start single cycle", timer_start, 0);
        step(D - 1);
        chk("R5 no buzzer one cycle early", buzzer, 0);
        chk("R5 still seated one cycle early", state_o, 1);
        step(1);
        chk("R5 buzzer at D+1 cycles", buzzer, 1);
        chk("R5 alarm state", state_o, 3);

        // R1 reset from alarm
        rst = 1'b1;
        step(1);
        chk("R1 reset from alarm state", state_o, 0);
        chk("R1 reset from alarm buzzer", buzzer, 0);
        rst = 1'b0;
        seat_in = 1'b0;
        step(5);

        // R7 belt seen on the expiry cycle
        seat_in = 1'b1;
        step(D + 1);
        belt_in = 1'b1;
        step(2);
        chk("R7 seated on expiry cycle", state_o, 1);
        step(1);
        chk("R7 belt wins over expiry", state_o, 2);
        chk("R7 no buzzer", buzzer, 0);
        seat_in = 1'b0; belt_in = 1'b0;
        step(5);

        // R9 belt one cycle after expiry
        seat_in = 1'b1;
        step(D + 2);
        belt_in = 1'b1;
        step(2);
        chk("R9 alarm before late belt", state_o, 3);
        chk("R9 buzzer before late belt", buzzer, 1);
        step(1);
        chk("R9 belted after late belt", state_o, 2);
        chk("R9 buzzer cleared", buzzer, 0);

        // R10 unbelt restarts full interval
        step(3);
        belt_in = 1'b0;
        step(3);
        chk("R10 back to seated", state_o, 1);
        chk("R10 timer_start again", timer_start, 1);
        step(D);
        chk("R10 no buzzer before full interval", buzzer, 0);
        step(1);
        chk("R10 buzzer after full interval", buzzer, 1);

        // R8 leave during alarm, latency R4
        seat_in = 1'b0;
        step(2);
        chk("R4 alarm held two edges after leaving", state_o, 3);
        step(1);
        chk("R8 empty after leaving alarm", state_o, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule